// File: doc/BRIEF.md
# Strobe-Sequenced Scratchpad Memory

This block is a small read/write scratchpad of 64 words, 4 bits each. The storage is made of four banks of 16 words. An internal synchronous address counter supplies the address. The upper two address bits select the one bank that takes part in an access. A 4-bit output register presents the data.

A single control strobe sequences everything. While the strobe is low, the output register follows the addressed word. In write mode, the strobe low phase is also the write pulse. When the strobe rises, the output freezes and the address counter takes its next value. So every strobe cycle reads or writes the word whose address was set by the previous rising edge.

The strobe is a synchronous input, sampled by the system clock. The storage and the output both update on clock edges while the sampled strobe is low. The counter updates on the clock edge that first sees the strobe high after it was low.

Top module: `scratchpad_strobed`

## Requirements
- R1: After reset, `dout` is 0, the address counter is 0 and every one of the 64 words reads as 0.
- R2: With `mode` = 2'b01 sampled at a strobe rising edge, the address counter increments by one, and it wraps from 63 to 0.
- R3: With `mode` = 2'b10 sampled at a strobe rising edge, the address counter takes the value of `load_addr`.
- R4: With `mode` = 2'b00 or 2'b11 sampled at a strobe rising edge, the address counter keeps its value.
- R5: The address counter changes only on a strobe rising edge. The values of `mode` and `load_addr` at any other time have no effect.
- R6: While the strobe is low and `wr_mode` = 1, the word at the current address is written with `din` on every clock edge. The value sampled on the last clock edge of the low phase is the value that stays stored.
- R7: While `wr_mode` = 0, no word of the storage changes, whatever the strobe level and `din`.
- R8: While the strobe is low, `dout` is loaded on each clock edge. In read mode it takes the word at the current address. In write mode it takes `din` (write-through).
- R9: While the strobe is high, `dout` holds its value, so the result of a strobe cycle stays valid until the strobe next goes low.
- R10: Address bits [5:4] select the bank and bits [3:0] the word within it. A write changes only the selected bank, so words with equal low bits in different banks are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Shared strobe: low = access phase, rising edge = address step |
| mode | input | 2 | Counter mode: 00 hold, 01 count up, 10 load, 11 hold |
| load_addr | input | 6 | Address taken by the counter in load mode |
| wr_mode | input | 1 | 1 = write access, 0 = read access |
| din | input | 4 | Write data |
| dout | output | 4 | Output register data |

## Verification
A clock edge that samples the strobe low updates the storage and `dout` on that same edge. The new value can therefore be read half a clock later. The address step happens on the first edge that samples the strobe high, so its effect appears only in the data of the next low phase.

The bench drives every input on falling clock edges. Each strobe cycle lasts two clocks low and two clocks high. `dout` is compared at the falling edge that ends the low phase, and again at the falling edge that ends the high phase. This confirms both the captured value and that it is held.

A bench-side array and address model predicts each result from the requirements. It applies the write in the low phase and steps the address at the rising edge, in that order.

// File: rtl/scratch_pkg.sv
package scratch_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD     = 2'b00,
    MODE_COUNT    = 2'b01,
    MODE_LOAD     = 2'b10,
    MODE_HOLD_ALT = 2'b11
  } step_mode_e;

  // Next counter value. Counter widths up to 16 bits; the caller truncates,
  // which gives the wrap for power-of-two depths.
  function automatic logic [15:0] step_address(input logic [15:0] cur,
                                               input logic [15:0] ld,
                                               input step_mode_e  m);
    logic [15:0] r;
    case (m)
      MODE_COUNT: r = cur + 16'd1;
      MODE_LOAD:  r = ld;
      default:    r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/addr_counter.sv
module addr_counter
  import scratch_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  step_mode_e        mode,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_nxt;

  always_comb begin
    addr_nxt = ADDR_W'(step_address(16'(addr), 16'(load_addr), mode));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else if (step) addr <= addr_nxt;
  end

endmodule

// File: rtl/bank_decoder.sv
module bank_decoder #(
  parameter int NUM_BANKS = 4,
  localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [SEL_W-1:0]     bank_idx,
  input  logic                 enable,
  output logic [NUM_BANKS-1:0] sel
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    assign sel[b] = enable && (bank_idx == SEL_W'(b));
  end

endmodule

// File: rtl/ram_bank.sv
module ram_bank #(
  parameter int WORDS  = 16,
  parameter int DATA_W = 4,
  localparam int AW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] cells [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) cells[i] <= '0;
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign q = cells[addr];

endmodule

// File: rtl/out_latch.sv
module out_latch #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_n,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  // Follows d while open_n is low, holds while it is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (!open_n) q <= d;
  end

endmodule

// File: rtl/scratchpad_strobed.sv
module scratchpad_strobed
  import scratch_pkg::*;
#(
  parameter int DATA_W     = 4,
  parameter int BANK_WORDS = 16,
  parameter int NUM_BANKS  = 4,
  localparam int LOW_W  = $clog2(BANK_WORDS),
  localparam int SEL_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W = LOW_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              wr_mode,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic                 strobe_q;
  logic                 strobe_rise;
  logic                 write_phase;
  logic [ADDR_W-1:0]    cur_addr;
  logic [SEL_W-1:0]     bank_idx;
  logic [LOW_W-1:0]     word_idx;
  logic [NUM_BANKS-1:0] bank_we;
  logic [DATA_W-1:0]    bank_q [NUM_BANKS];
  logic [DATA_W-1:0]    rd_word;
  logic [DATA_W-1:0]    latch_d;

  // Idle level of the strobe is high, so reset to 1 to avoid a false edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b1;
    else strobe_q <= strobe;
  end

  assign strobe_rise = strobe && !strobe_q;
  assign write_phase = !strobe && wr_mode;
  assign bank_idx    = cur_addr[ADDR_W-1:LOW_W];
  assign word_idx    = cur_addr[LOW_W-1:0];

  addr_counter #(.ADDR_W(ADDR_W)) i_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (strobe_rise),
    .mode      (step_mode_e'(mode)),
    .load_addr (load_addr),
    .addr      (cur_addr)
  );

  bank_decoder #(.NUM_BANKS(NUM_BANKS)) i_decoder (
    .bank_idx (bank_idx),
    .enable   (write_phase),
    .sel      (bank_we)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ram_bank #(.WORDS(BANK_WORDS), .DATA_W(DATA_W)) i_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we[b]),
      .addr  (word_idx),
      .wdata (din),
      .q     (bank_q[b])
    );
  end

  assign rd_word = bank_q[bank_idx];
  assign latch_d = wr_mode ? din : rd_word;

  out_latch #(.DATA_W(DATA_W)) i_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .open_n (strobe),
    .d      (latch_d),
    .q      (dout)
  );

endmodule

// File: rtl/scratchpad_checker.sv
module scratchpad_checker #(
  parameter int DATA_W    = 4,
  parameter int ADDR_W    = 6,
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 strobe,
  input logic [1:0]           mode,
  input logic [ADDR_W-1:0]    load_addr,
  input logic                 wr_mode,
  input logic                 rise,
  input logic [ADDR_W-1:0]    addr,
  input logic [NUM_BANKS-1:0] bank_we,
  input logic [DATA_W-1:0]    dout
);

  localparam logic [ADDR_W-1:0] ONE = 1;

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && mode == 2'b01) |=> addr == $past(addr) + ONE);

  assert_load_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && mode == 2'b10) |=> addr == $past(load_addr));

  assert_hold_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && (mode == 2'b00 || mode == 2'b11)) |=> $stable(addr));

  assert_addr_only_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(addr));

  assert_read_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |-> bank_we == '0);

  assert_no_write_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> bank_we == '0);

  assert_dout_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> $stable(dout));

  assert_one_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

endmodule

bind scratchpad_strobed scratchpad_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)
) i_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .strobe    (strobe),
  .mode      (mode),
  .load_addr (load_addr),
  .wr_mode   (wr_mode),
  .rise      (strobe_rise),
  .addr      (cur_addr),
  .bank_we   (bank_we),
  .dout      (dout)
);

// File: tb/test_scratchpad_strobed.sv
module test_scratchpad_strobed;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b1;
  logic [1:0] mode = 2'b00;
  logic [5:0] load_addr = '0;
  logic       wr_mode = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] dout;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [3:0] ref_mem [64];
  logic [5:0] ref_addr;

  always #4 clk = ~clk;  // 125 MHz

  scratchpad_strobed i_scratchpad_strobed (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .mode(mode),
    .load_addr(load_addr), .wr_mode(wr_mode), .din(din), .dout(dout)
  );

  function automatic logic [5:0] next_ref_addr(input logic [5:0] a,
                                               input logic [1:0] m,
                                               input logic [5:0] ld);
    if (m == 2'b01) return (a == 6'd63) ? 6'd0 : a + 6'd1;
    if (m == 2'b10) return ld;
    return a;
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: dout=%h expected=%h", tag, got, exp);
    end
  endtask

  // One strobe cycle: two clocks low, two clocks high.
  // low_mode/low_ld are applied during the low phase only (must be ignored, R5).
  task automatic pulse(input logic [1:0] m, input logic [5:0] ld, input logic wr,
                       input logic [3:0] d0, input logic [3:0] d1,
                       input logic [1:0] low_mode, input logic [5:0] low_ld,
                       input string tag);
    logic [3:0] exp;
    @(negedge clk);
    strobe = 1'b0; wr_mode = wr; din = d0; mode = low_mode; load_addr = low_ld;
    @(negedge clk);
    din = d1;
    @(negedge clk);
    if (wr) ref_mem[ref_addr] = d1;
    exp = wr ? d1 : ref_mem[ref_addr];
    check(tag, dout, exp);
    strobe = 1'b1; mode = m; load_addr = ld;
    ref_addr = next_ref_addr(ref_addr, m, ld);
    @(negedge clk);
    din = ~d1; wr_mode = ~wr; mode = low_mode; load_addr = low_ld;
    @(negedge clk);
    check("R9", dout, exp);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd7031);
    for (int i = 0; i < 64; i++) ref_mem[i] = 4'h0;
    ref_addr = 6'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", dout, 4'h0);

    // R1: storage reads zero after reset, walk a few words
    for (int i = 0; i < 4; i++) pulse(2'b01, 6'd0, 1'b0, 4'h5, 4'h5, 2'b10, 6'd33, "R1");

    // R2/R3/R6: load 60, write 8 words while counting through the 63->0 wrap
    pulse(2'b10, 6'd60, 1'b0, 4'h0, 4'h0, 2'b00, 6'd0, "R8");
    for (int i = 0; i < 8; i++)
      pulse(2'b01, 6'd0, 1'b1, 4'hF, 4'(i + 3), 2'b10, 6'd12, "R6");
    pulse(2'b10, 6'd60, 1'b0, 4'h0, 4'h0, 2'b00, 6'd0, "R3");
    for (int i = 0; i < 8; i++)
      pulse(2'b01, 6'd0, 1'b0, 4'hA, 4'hA, 2'b00, 6'd0, "R2");

    // R10: same low bits in different banks
    pulse(2'b10, 6'd5, 1'b0, 4'h0, 4'h0, 2'b00, 6'd0, "R8");
    pulse(2'b10, 6'd21, 1'b1, 4'h0, 4'h9, 2'b00, 6'd0, "R10");
    pulse(2'b10, 6'd37, 1'b1, 4'h0, 4'hC, 2'b00, 6'd0, "R10");
    pulse(2'b10, 6'd5, 1'b0, 4'h0, 4'h0, 2'b00, 6'd0, "R10");
    pulse(2'b10, 6'd21, 1'b0, 4'h0, 4'h0, 2'b00, 6'd0, "R10");
    pulse(2'b00, 6'd0, 1'b0, 4'h0, 4'h0, 2'b00, 6'd0, "R10");

    // R4: both hold encodings keep the address
    pulse(2'b00, 6'd0, 1'b1, 4'h0, 4'h6, 2'b00, 6'd0, "R6");
    pulse(2'b11, 6'd0, 1'b0, 4'h0, 4'h0, 2'b10, 6'd2, "R4");
    pulse(2'b00, 6'd9, 1'b0, 4'h0, 4'h0, 2'b01, 6'd2, "R4");

    // R7: read with differing din leaves the word unchanged
    pulse(2'b00, 6'd0, 1'b0, 4'h1, 4'hE, 2'b00, 6'd0, "R7");
    pulse(2'b00, 6'd0, 1'b0, 4'h2, 4'hD, 2'b00, 6'd0, "R7");

    // R5: load requested only during the low phase is ignored
    pulse(2'b00, 6'd0, 1'b0, 4'h0, 4'h0, 2'b10, 6'd50, "R5");
    pulse(2'b00, 6'd0, 1'b0, 4'h0, 4'h0, 2'b10, 6'd51, "R5");

    // Random mix against the model
    for (int n = 0; n < 400; n++) begin
      logic [1:0] rm;
      logic       rw;
      rm = 2'($urandom_range(0, 3));
      rw = 1'($urandom_range(0, 1));
      pulse(rm, 6'($urandom), rw, 4'($urandom), 4'($urandom),
            2'($urandom), 6'($urandom), rw ? "R6" : "R8");
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected=completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule